// File: doc/BRIEF.md
# Soft-Weight Revision Window for a Four-Symbol Decoder

This block sits at the back end of a soft-output trellis decoder for a two-bit-per-step code. Each accepted step brings four incoming branch metrics for the decided state and the symbol histories of three concurrent paths. The block picks the principal symbol as the branch with the smallest metric. It forms the other three reliabilities as metric differences, saturated to 6 bits. It stores only those three values, in rows addressed relative to the principal symbol, and keeps the principal symbol as a key beside them.

As an entry ages through a window of `DEPTH` steps, every later step may lower its weights. A concurrent path whose history names a non-principal symbol at that age caps that symbol's weight at the path's own initial weight. The oldest entry leaves the window with its weights put back into natural symbol order, and the principal symbol reads as zero.

The window is controlled by a small fill state machine with three states. EMPTY holds no entries. FILL holds some entries but fewer than `DEPTH`. FULL means the oldest stage holds a real entry. The transitions are: EMPTY to FILL on the first accepted step, FILL to FILL on an accepted step that does not complete the window, FILL to FULL on the step that fills the last stage, and FULL to FULL on every later step. Reset returns the machine to EMPTY.

Top module: `sova_weight_reviser`

## Requirements
- R1: After reset, `out_valid`, `out_sym` and `out_w` are all zero. Outputs stay zero for as long as `out_valid` is low.
- R2: The principal symbol is the index k (0..3) of the smallest `in_metric` field. When several fields tie, the lowest index wins. For every other symbol k, the initial weight is metric k minus that minimum, and values above 63 become 63.
- R3: `out_valid` rises after the `DEPTH`-th accepted step (`in_valid` high at a rising edge) and then stays high. A cycle with `in_valid` low changes no output.
- R4: With `out_valid` high, `out_sym` is the principal symbol of the step accepted `DEPTH` steps earlier. `out_w[k*6 +: 6]` is that step's weight for symbol k, and the field for `out_sym` is zero.
- R5: Concurrent path r (r = 1..3) of a step belongs to symbol p XOR r, where p is that step's principal symbol. Its history symbol for the entry accepted j steps earlier (j = 1..`DEPTH`-1) is `in_path[((r-1)*(DEPTH-1)+j-1)*2 +: 2]`. If that history symbol a differs from that entry's principal symbol, the entry's weight for a becomes min(weight, initial weight of p XOR r).
- R6: A history symbol equal to the principal symbol of the entry it refers to leaves that entry unchanged.
- R7: When several paths name the same symbol of the same entry in one step, the weight becomes the minimum of the old value and all of those paths' initial weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept a step this cycle |
| in_metric | input | 4*MW | Incoming metrics, symbol k in bits [k*MW +: MW] |
| in_path | input | 3*(DEPTH-1)*2 | Concurrent path histories, layout per R5 |
| out_valid | output | 1 | Oldest window stage holds a real entry |
| out_sym | output | 2 | Principal symbol of the leaving entry |
| out_w | output | 4*WW | Weights in natural order, symbol k in bits [k*WW +: WW] |

## Verification
The bench targets metric ties and saturated differences. A design that mishandles them would pick the wrong principal symbol or wrap a large difference to a small weight. It drives history symbols equal to the stored key, where a design that skipped the XOR of history and key would corrupt row zero or the wrong row. It also drives three paths that converge on one symbol, where keeping the last writer instead of the minimum shows up as a raised weight. Idle cycles and the exact step on which the window fills are checked as well, which catches an off-by-one fill count or a window that shifts without `in_valid`.

// File: rtl/sova_rev_pkg.sv
package sova_rev_pkg;

    typedef logic [1:0] sym_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/sova_init_weights.sv
module sova_init_weights #(
    parameter int MW = 8,
    parameter int WW = 6
) (
    input  logic [4*MW-1:0] metric,
    output logic [1:0]      key,
    output logic [3*WW-1:0] rows
);
    localparam logic [MW-1:0] CAP = MW'((1 << WW) - 1);

    logic [MW-1:0] m [4];
    logic [MW-1:0] lo01, lo23, lo_all;
    logic [1:0]    i01, i23;
    logic [1:0]    sym_r;
    logic [MW-1:0] diff;

    always_comb begin
        for (int k = 0; k < 4; k++) begin
            m[k] = metric[k*MW +: MW];
        end
        // first comparator level: pairs, lower index wins ties
        if (m[1] < m[0]) begin
            lo01 = m[1];
            i01  = 2'd1;
        end else begin
            lo01 = m[0];
            i01  = 2'd0;
        end
        if (m[3] < m[2]) begin
            lo23 = m[3];
            i23  = 2'd3;
        end else begin
            lo23 = m[2];
            i23  = 2'd2;
        end
        // second comparator level
        if (lo23 < lo01) begin
            lo_all = lo23;
            key    = i23;
        end else begin
            lo_all = lo01;
            key    = i01;
        end
        rows  = '0;
        sym_r = '0;
        diff  = '0;
        for (int r = 1; r < 4; r++) begin
            sym_r = key ^ 2'(r);
            diff  = m[sym_r] - lo_all;
            rows[(r-1)*WW +: WW] = (diff > CAP) ? CAP[WW-1:0] : diff[WW-1:0];
        end
    end

endmodule

// File: rtl/sova_rev_stage.sv
module sova_rev_stage #(
    parameter int WW = 6
) (
    input  logic [3*WW-1:0] old_rows,
    input  logic [1:0]      key,
    input  logic [5:0]      hist,
    input  logic [3*WW-1:0] pw,
    output logic [3*WW-1:0] new_rows
);
    logic [WW-1:0] cand [3];
    logic [WW-1:0] lvl_a, lvl_b;
    logic [WW-1:0] old_v;

    always_comb begin
        new_rows = '0;
        lvl_a    = '0;
        lvl_b    = '0;
        old_v    = '0;
        for (int q = 1; q < 4; q++) begin
            for (int r = 0; r < 3; r++) begin
                // relative row named by path r at this age
                if ((hist[r*2 +: 2] ^ key) == 2'(q)) begin
                    cand[r] = pw[r*WW +: WW];
                end else begin
                    cand[r] = '1;
                end
            end
            old_v = old_rows[(q-1)*WW +: WW];
            lvl_a = (cand[0] < old_v)   ? cand[0] : old_v;
            lvl_b = (cand[2] < cand[1]) ? cand[2] : cand[1];
            new_rows[(q-1)*WW +: WW] = (lvl_b < lvl_a) ? lvl_b : lvl_a;
        end
    end

endmodule

// File: rtl/sova_unshuffle.sv
module sova_unshuffle #(
    parameter int WW = 6
) (
    input  logic [1:0]      key,
    input  logic [3*WW-1:0] rows,
    output logic [4*WW-1:0] nat_w
);
    logic [1:0] rel;

    always_comb begin
        nat_w = '0;
        rel   = '0;
        for (int k = 0; k < 4; k++) begin
            rel = 2'(k) ^ key;
            unique case (rel)
                2'd0: nat_w[k*WW +: WW] = '0;
                2'd1: nat_w[k*WW +: WW] = rows[0*WW +: WW];
                2'd2: nat_w[k*WW +: WW] = rows[1*WW +: WW];
                2'd3: nat_w[k*WW +: WW] = rows[2*WW +: WW];
            endcase
        end
    end

endmodule

// File: rtl/sova_weight_reviser.sv
module sova_weight_reviser
    import sova_rev_pkg::*;
#(
    parameter int MW    = 8,
    parameter int WW    = 6,
    parameter int DEPTH = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [4*MW-1:0]            in_metric,
    input  logic [3*(DEPTH-1)*2-1:0]   in_path,
    output logic                       out_valid,
    output logic [1:0]                 out_sym,
    output logic [4*WW-1:0]            out_w
);
    localparam int HD   = DEPTH - 1;
    localparam int ROWW = 3 * WW;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] LAST = CW'(DEPTH - 1);

    fill_state_t     state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;

    sym_t            key_q [DEPTH];
    logic [ROWW-1:0] wt_q  [DEPTH];
    logic [ROWW-1:0] wt_rev [HD];

    sym_t            new_key;
    logic [ROWW-1:0] new_rows;
    logic [4*WW-1:0] nat_w;

    sova_init_weights #(.MW(MW), .WW(WW)) u_init (
        .metric (in_metric),
        .key    (new_key),
        .rows   (new_rows)
    );

    for (genvar d = 0; d < HD; d++) begin : g_stage
        logic [5:0] hist_d;
        for (genvar r = 0; r < 3; r++) begin : g_path
            assign hist_d[r*2 +: 2] = in_path[(r*HD + d)*2 +: 2];
        end
        sova_rev_stage #(.WW(WW)) u_rev (
            .old_rows (wt_q[d]),
            .key      (key_q[d]),
            .hist     (hist_d),
            .pw       (new_rows),
            .new_rows (wt_rev[d])
        );
    end

    // window storage: key shift array and shuffled weight rows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) begin
                key_q[d] <= '0;
                wt_q[d]  <= '0;
            end
        end else if (in_valid) begin
            key_q[0] <= new_key;
            wt_q[0]  <= new_rows;
            for (int d = 1; d < DEPTH; d++) begin
                key_q[d] <= key_q[d-1];
                wt_q[d]  <= wt_rev[d-1];
            end
        end
    end

    sova_unshuffle #(.WW(WW)) u_unshuf (
        .key   (key_q[DEPTH-1]),
        .rows  (wt_q[DEPTH-1]),
        .nat_w (nat_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid) begin
                    state_d = ST_FILL;
                    cnt_d   = CW'(1);
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    cnt_d = cnt_q + CW'(1);
                    if (cnt_q == LAST) begin
                        state_d = ST_FULL;
                    end
                end
            end
            ST_FULL: begin
                state_d = ST_FULL;
            end
            default: begin
                state_d = ST_EMPTY;
                cnt_d   = '0;
            end
        endcase
    end

    // output logic
    always_comb begin
        out_valid = 1'b0;
        out_sym   = '0;
        out_w     = '0;
        unique case (state_q)
            ST_EMPTY, ST_FILL: begin
                out_valid = 1'b0;
            end
            ST_FULL: begin
                out_valid = 1'b1;
                out_sym   = key_q[DEPTH-1];
                out_w     = nat_w;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sova_weight_reviser_chk.sv
module sova_weight_reviser_chk #(
    parameter int WW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic            out_valid,
    input logic [1:0]      out_sym,
    input logic [4*WW-1:0] out_w
);
    // R4: the principal symbol always reads as zero weight
    a_r4_principal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_w[out_sym*WW +: WW] == '0));

    // R3: once the window is full it stays full
    a_r3_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> out_valid);

    // R3: an idle cycle changes no output
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_w) && $stable(out_sym) && $stable(out_valid)));

    // R1: outputs are quiet while the window is not full
    a_r1_quiet_until_full: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_w == '0 && out_sym == '0));
endmodule

bind sova_weight_reviser sova_weight_reviser_chk #(.WW(WW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_sym   (out_sym),
    .out_w     (out_w)
);

// File: tb/sova_weight_reviser_test.sv
module sova_weight_reviser_test;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 8;
    localparam int WW = 6;
    localparam int DEPTH = 10;
    localparam int HD = DEPTH - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [4*MW-1:0] in_metric = '0;
    logic [3*HD*2-1:0] in_path = '0;
    logic out_valid;
    logic [1:0] out_sym;
    logic [4*WW-1:0] out_w;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int cur_m [4];
    int cur_h [3][HD];
    int ref_w [DEPTH][4];
    int ref_k [DEPTH];
    int ref_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sova_weight_reviser #(.MW(MW), .WW(WW), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_metric(in_metric), .in_path(in_path),
        .out_valid(out_valid), .out_sym(out_sym), .out_w(out_w)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_model(input string tag);
        bit v;
        v = (ref_cnt >= DEPTH);
        chk({tag, " valid"}, int'(out_valid), int'(v));
        chk({tag, " sym"}, int'(out_sym), v ? ref_k[DEPTH-1] : 0);
        for (int k = 0; k < 4; k++)
            chk({tag, " weight"}, int'(out_w[k*WW +: WW]), v ? ref_w[DEPTH-1][k] : 0);
    endtask

    function automatic int principal();
        int s = 0;
        for (int k = 1; k < 4; k++) if (cur_m[k] < cur_m[s]) s = k;
        return s;
    endfunction

    // drive cur_m/cur_h, clock once, update model, sample at negedge
    task automatic step(input bit v);
        int s;
        int p [4];
        int w [4];
        s = principal();
        for (int k = 0; k < 4; k++) begin
            p[k] = cur_m[k] - cur_m[s];
            if (p[k] > 63) p[k] = 63;
            in_metric[k*MW +: MW] = MW'(cur_m[k]);
        end
        for (int r = 0; r < 3; r++)
            for (int d = 0; d < HD; d++)
                in_path[(r*HD + d)*2 +: 2] = 2'(cur_h[r][d]);
        in_valid = v;
        @(posedge clk);
        if (v) begin
            for (int pos = DEPTH-1; pos >= 1; pos--) begin
                for (int k = 0; k < 4; k++) w[k] = ref_w[pos-1][k];
                for (int r = 1; r < 4; r++) begin
                    int a;
                    a = cur_h[r-1][pos-1];
                    if (a != ref_k[pos-1] && p[s ^ r] < w[a]) w[a] = p[s ^ r];
                end
                for (int k = 0; k < 4; k++) ref_w[pos][k] = w[k];
                ref_k[pos] = ref_k[pos-1];
            end
            for (int k = 0; k < 4; k++) ref_w[0][k] = (k == s) ? 0 : p[k];
            ref_k[0] = s;
            ref_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic hist_keys();
        for (int r = 0; r < 3; r++)
            for (int d = 0; d < HD; d++) cur_h[r][d] = ref_k[d];
    endtask

    task automatic rand_metrics();
        int base;
        base = $urandom_range(0, 150);
        for (int k = 0; k < 4; k++) cur_m[k] = base + $urandom_range(0, 100);
    endtask

    task automatic rand_hist();
        for (int r = 0; r < 3; r++)
            for (int d = 0; d < HD; d++)
                cur_h[r][d] = ($urandom_range(0, 1) == 1) ? ref_k[d] : $urandom_range(0, 3);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_v;
        seed_v = $urandom(32'd20240611);
        for (int k = 0; k < 4; k++) cur_m[k] = 0;
        for (int r = 0; r < 3; r++) for (int d = 0; d < HD; d++) cur_h[r][d] = 0;
        for (int i = 0; i < DEPTH; i++) begin
            ref_k[i] = 0;
            for (int k = 0; k < 4; k++) ref_w[i][k] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset sym", int'(out_sym), 0);
        chk("R1 reset weights", int'(out_w), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 tie and saturation; R6 history equal to keys does nothing
        cur_m[0] = 100; cur_m[1] = 20; cur_m[2] = 20; cur_m[3] = 200;
        hist_keys();
        step(1'b1);
        for (int i = 1; i < DEPTH; i++) begin
            chk("R3 not yet valid", int'(out_valid), 0);
            chk("R1 quiet while filling", int'(out_w), 0);
            rand_metrics();
            hist_keys();
            step(1'b1);
        end
        chk("R3 valid after DEPTH steps", int'(out_valid), 1);
        chk("R2 tie picks lowest index", int'(out_sym), 1);
        chk("R2 saturated weight sym0", int'(out_w[0*WW +: WW]), 63);
        chk("R4 principal weight zero", int'(out_w[1*WW +: WW]), 0);
        chk("R2 tied weight sym2", int'(out_w[2*WW +: WW]), 0);
        chk("R6 saturated weight sym3", int'(out_w[3*WW +: WW]), 63);

        // R3: idle cycles with junk inputs hold everything
        for (int i = 0; i < 5; i++) begin
            rand_metrics();
            rand_hist();
            step(1'b0);
            check_model("R3 idle hold");
        end

        // R7: all three paths converge on one non-key symbol per age
        for (int i = 0; i < 40; i++) begin
            rand_metrics();
            for (int d = 0; d < HD; d++) begin
                int a;
                a = (ref_k[d] + 1 + $urandom_range(0, 2)) % 4;
                for (int r = 0; r < 3; r++) cur_h[r][d] = a;
            end
            step(1'b1);
            check_model("R7 converging paths");
        end

        // R5/R4: random mix with occasional idle cycles
        for (int i = 0; i < 400; i++) begin
            bit v;
            rand_metrics();
            rand_hist();
            v = ($urandom_range(0, 7) != 0);
            step(v);
            check_model(v ? "R5 random revision" : "R3 random idle");
        end

        // R2: extreme metric spread
        for (int i = 0; i < 20; i++) begin
            for (int k = 0; k < 4; k++) cur_m[k] = $urandom_range(0, 255);
            rand_hist();
            step(1'b1);
            check_model("R2 wide spread R4");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule